// File: doc/BRIEF.md
# NAND Ready-Status Poller

This block waits for a raw NAND device to finish an internal operation and classifies the outcome. A one-cycle `start` pulse makes it send the read-status command once, on the command-latch write strobe. It then reads the status byte again and again on the data-read strobe. It stops when the status shows the device is ready, or when the number of reads reaches a fixed limit. The bus is an 8-bit path with four single-cycle strobes. Device timing is not modelled: each strobe lasts one clock. The address-latch and data-write strobes exist on the bus but this operation never uses them.

The controller is a five-state machine:

- `ST_IDLE` waits for `start`.
- `ST_ISSUE` drives the command byte.
- `ST_READ` pulses the read strobe and captures the status byte.
- `ST_JUDGE` decodes the captured byte.
- `ST_REPORT` raises `done` for one cycle.

The transitions are:

| Name | From | To | Condition |
|------|------|----|-----------|
| go | `ST_IDLE` | `ST_ISSUE` | on `start` |
| issued | `ST_ISSUE` | `ST_READ` | always |
| sampled | `ST_READ` | `ST_JUDGE` | always |
| repoll | `ST_JUDGE` | `ST_READ` | not ready and limit not reached |
| settle | `ST_JUDGE` | `ST_REPORT` | ready, or limit reached |
| finish | `ST_REPORT` | `ST_IDLE` | always |

The outcome is held on a 2-bit code until the next accepted start. Each poll iteration takes two clocks: one read and one decode.

Top module: `nand_status_poller`

## Requirements
- R1: After an accepted `start`, exactly one command-latch write is made with byte 0x70 on `bus_wdata`, and it comes before any data read.
- R2: Every later poll is one data-read strobe only; the command is not written again during the same operation.
- R3: When the captured status has bit 6 set and bit 0 clear, the result is 01 (ok), whatever the other bits hold. A byte with bit 6 clear never ends the poll, even if bit 0 is set.
- R4: When the captured status has bit 6 set and bit 0 set, the result is 10 (device error).
- R5: If POLL_LIMIT reads (default 100000) pass without bit 6 set, the result is 11 (timeout) after exactly POLL_LIMIT reads. A ready status on the final allowed read still counts as ready.
- R6: `done` is high for exactly one cycle, together with a non-zero result. The result reads 00 after reset and throughout a poll, and it holds its final value until the next accepted start.
- R7: A `start` that arrives while a poll is in progress is ignored: no new command, no extra `done`, and no change to the read count or the outcome.
- R8: The read counter (17 bits at the default limit) is cleared at every accepted start, so each operation gets the full POLL_LIMIT reads.
- R9: The address-latch write and data-write strobes are never asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a status poll (taken only when idle) |
| done | output | 1 | One-cycle pulse when the outcome is known |
| result | output | 2 | 00 busy, 01 ok, 10 device error, 11 timeout |
| cmd_latch_wr | output | 1 | Command-latch write strobe |
| addr_latch_wr | output | 1 | Address-latch write strobe (held low) |
| data_wr | output | 1 | Data write strobe (held low) |
| data_rd | output | 1 | Data read strobe; the status byte is captured at the end of this cycle |
| bus_wdata | output | 8 | Byte driven toward the device |
| bus_rdata | input | 8 | Status byte returned by the device |

## Verification
The device model answers with a chosen number of busy bytes and then a final byte. The patterns are chosen so each one tells apart a specific pair of outcomes:

- An immediately ready device shows the shortest path.
- Busy bytes that carry the fail bit but not the ready bit show that only bit 6 ends the poll.
- Ready bytes with unrelated high bits set show that those bits do not matter.
- A final byte with both bits set separates device error from success.
- A device that is never ready, compared with one that becomes ready on exactly the last allowed read, pins the timeout boundary to the exact read count.

A repeated timeout shows that the counter restarts. A second `start` pulsed during a poll must leave the command count, the read count and the outcome unchanged.

// File: rtl/nsp_pkg.sv
package nsp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_READ,
        ST_JUDGE,
        ST_REPORT
    } poll_state_t;

    typedef enum logic [1:0] {
        RES_BUSY    = 2'b00,
        RES_OK      = 2'b01,
        RES_ERR     = 2'b10,
        RES_TIMEOUT = 2'b11
    } poll_result_t;

    typedef enum logic [1:0] {
        BUS_NONE,
        BUS_CMD,
        BUS_READ
    } bus_op_t;

    localparam logic [7:0] STATUS_CMD = 8'h70;

endpackage

// File: rtl/nsp_bus_master.sv
module nsp_bus_master
    import nsp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_op_t       op,
    input  logic [DW-1:0] cmd_byte,
    input  logic [DW-1:0] rdata,
    output logic          cmd_wr,
    output logic          addr_wr,
    output logic          dat_wr,
    output logic          dat_rd,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] status_q
);

    always_comb begin
        cmd_wr  = (op == BUS_CMD);
        dat_rd  = (op == BUS_READ);
        addr_wr = 1'b0;
        dat_wr  = 1'b0;
        wdata   = cmd_wr ? cmd_byte : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (dat_rd) begin
            status_q <= rdata;
        end
    end

    AST_CAPTURE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dat_rd |=> (status_q == $past(rdata))); // R2

endmodule

// File: rtl/nsp_read_counter.sv
module nsp_read_counter #(
    parameter int LIMIT = 100000,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    output logic [CW-1:0] count,
    output logic          at_limit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    assign at_limit = (count == CW'(LIMIT));

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(LIMIT)); // R5

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0)); // R8

endmodule

// File: rtl/nsp_status_decode.sv
module nsp_status_decode #(
    parameter int DW        = 8,
    parameter int READY_BIT = 6,
    parameter int FAIL_BIT  = 0
) (
    input  logic [DW-1:0] status,
    output logic          ready,
    output logic          fail
);

    assign ready = status[READY_BIT];
    assign fail  = status[FAIL_BIT];

endmodule

// File: rtl/nand_status_poller.sv
module nand_status_poller
    import nsp_pkg::*;
#(
    parameter int POLL_LIMIT = 100000,
    parameter int READY_BIT  = 6,
    parameter int FAIL_BIT   = 0,
    localparam int DW        = 8,
    localparam int CW        = $clog2(POLL_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          done,
    output logic [1:0]    result,
    output logic          cmd_latch_wr,
    output logic          addr_latch_wr,
    output logic          data_wr,
    output logic          data_rd,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);

    poll_state_t  state_q, state_d;
    poll_result_t res_q;
    bus_op_t      op;
    logic         cnt_clear, cnt_inc, at_limit;
    logic         ready, fail;
    logic [CW-1:0] count;
    logic [DW-1:0] status_q;

    nsp_bus_master #(.DW(DW)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .cmd_byte (STATUS_CMD),
        .rdata    (bus_rdata),
        .cmd_wr   (cmd_latch_wr),
        .addr_wr  (addr_latch_wr),
        .dat_wr   (data_wr),
        .dat_rd   (data_rd),
        .wdata    (bus_wdata),
        .status_q (status_q)
    );

    nsp_read_counter #(.LIMIT(POLL_LIMIT)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .inc      (cnt_inc),
        .count    (count),
        .at_limit (at_limit)
    );

    nsp_status_decode #(.DW(DW), .READY_BIT(READY_BIT), .FAIL_BIT(FAIL_BIT)) u_dec (
        .status (status_q),
        .ready  (ready),
        .fail   (fail)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ISSUE;
            ST_ISSUE:  state_d = ST_READ;
            ST_READ:   state_d = ST_JUDGE;
            ST_JUDGE: begin
                if (ready || at_limit) state_d = ST_REPORT;
                else                   state_d = ST_READ;
            end
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outcome register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= RES_BUSY;
        end else if (state_q == ST_IDLE && start) begin
            res_q <= RES_BUSY;
        end else if (state_q == ST_JUDGE) begin
            if (ready)         res_q <= fail ? RES_ERR : RES_OK;
            else if (at_limit) res_q <= RES_TIMEOUT;
        end
    end

    // Outputs decoded from state
    always_comb begin
        op        = BUS_NONE;
        cnt_clear = 1'b0;
        cnt_inc   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   cnt_clear = start;
            ST_ISSUE:  op = BUS_CMD;
            ST_READ: begin
                op      = BUS_READ;
                cnt_inc = 1'b1;
            end
            ST_JUDGE:  ;
            ST_REPORT: done = 1'b1;
            default:   ;
        endcase
    end

    assign result = res_q;

    AST_CMD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_latch_wr |-> (bus_wdata == STATUS_CMD)); // R1

    AST_NO_CMD_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |=> !cmd_latch_wr); // R2

    AST_TIMEOUT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_TIMEOUT) |-> at_limit); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != RES_BUSY)); // R6

    AST_BUSY_WHILE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |-> (result == RES_BUSY)); // R6

    AST_UNUSED_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_latch_wr && !data_wr); // R9

endmodule

// File: tb/nand_status_poller_test.sv
module nand_status_poller_test;
    import nsp_pkg::*;

    localparam int LIMIT = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       done;
    logic [1:0] result;
    logic       cmd_latch_wr, addr_latch_wr, data_wr, data_rd;
    logic [7:0] bus_wdata, bus_rdata;

    always #4 clk = ~clk;

    nand_status_poller #(.POLL_LIMIT(LIMIT)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .done          (done),
        .result        (result),
        .cmd_latch_wr  (cmd_latch_wr),
        .addr_latch_wr (addr_latch_wr),
        .data_wr       (data_wr),
        .data_rd       (data_rd),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata)
    );

    // Device model
    int         busy_reads = 0;
    logic [7:0] busy_val   = 8'h00;
    logic [7:0] final_val  = 8'h40;
    int         rd_cnt = 0, cmd_cnt = 0, stray_cnt = 0, bad_cmd = 0, early_rd = 0;
    int         base_rd = 0;

    assign bus_rdata = ((rd_cnt - base_rd) >= busy_reads) ? final_val : busy_val;

    always @(posedge clk) begin
        if (cmd_latch_wr) begin
            cmd_cnt <= cmd_cnt + 1;
            if (bus_wdata != 8'h70) bad_cmd <= bad_cmd + 1;
        end
        if (data_rd) begin
            rd_cnt <= rd_cnt + 1;
            if (cmd_cnt == 0) early_rd <= early_rd + 1;
        end
        if (addr_latch_wr || data_wr) stray_cnt <= stray_cnt + 1;
    end

    int n_checks = 0, n_err = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [1:0] res;
        int         reads;
        int         rd0;
        int         cmd0;
        string      tag;
    } exp_t;

    exp_t sb[$];

    // Monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(result == e.res, e.tag, "result", int'(result), int'(e.res));
                check((rd_cnt - e.rd0) == e.reads, e.tag, "read count",
                      rd_cnt - e.rd0, e.reads);
                check((cmd_cnt - e.cmd0) == 1, "R2", "command writes",
                      cmd_cnt - e.cmd0, 1);
            end
        end
    end

    // Driver
    task automatic run_poll(input int nbusy, input logic [7:0] bval,
                            input logic [7:0] fval, input logic [1:0] eres,
                            input int ereads, input string tag, input bit poke);
        exp_t e;
        @(negedge clk);
        busy_reads = nbusy;
        busy_val   = bval;
        final_val  = fval;
        base_rd    = rd_cnt;
        e.res = eres; e.reads = ereads; e.rd0 = rd_cnt; e.cmd0 = cmd_cnt; e.tag = tag;
        sb.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(result == 2'b00, "R6", "result during poll", int'(result), 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 4 * LIMIT + 20 && sb.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(result == eres && !done, "R6", "result held after done",
              int'(result), int'(eres));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(result == 2'b00, "R6", "reset result", int'(result), 0);
        check(done == 1'b0, "R6", "reset done", int'(done), 0);
        check(!cmd_latch_wr && !data_rd, "R9", "reset strobes",
              int'({cmd_latch_wr, data_rd}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_poll(0,   8'h00, 8'h40, RES_OK,      1,     "R3", 0);
        run_poll(3,   8'h00, 8'h41, RES_ERR,     4,     "R4", 0);
        run_poll(5,   8'h81, 8'hE0, RES_OK,      6,     "R3", 0);
        run_poll(100, 8'h3F, 8'h40, RES_TIMEOUT, LIMIT, "R5", 0);
        run_poll(11,  8'hBF, 8'h40, RES_OK,      LIMIT, "R5", 0);
        run_poll(100, 8'h00, 8'h40, RES_TIMEOUT, LIMIT, "R8", 0);
        run_poll(4,   8'h00, 8'h41, RES_ERR,     5,     "R7", 1);
        run_poll(0,   8'h00, 8'h41, RES_ERR,     1,     "R4", 0);

        check(sb.size() == 0, "R6", "missing done", sb.size(), 0);
        check(early_rd == 0, "R1", "reads before command", early_rd, 0);
        check(bad_cmd == 0, "R1", "wrong command byte", bad_cmd, 0);
        check(stray_cnt == 0, "R9", "address/data-write strobes", stray_cnt, 0);
        check(cmd_cnt == 8, "R7", "total commands", cmd_cnt, 8);

        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(1'b0, "R6", "watchdog expired", 1, 0);
            $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule